// File: doc/BRIEF.md
# Active Window Cropper

The cropper sits on a raw pixel stream that arrives one bus word per clock together with active-high frame and line sync strobes. It counts clock cycles from each line sync and lines from each frame sync, and marks with a valid flag only the words that fall inside a programmed rectangle. The rectangle has a start column, a start line and two lengths. Columns are counted in bus cycles, not pixels, so a two-words-per-pixel format needs a doubled column window.

The four window settings are static inputs. They are copied into shadow registers on the rising edge of the frame sync, so a frame always uses one consistent window. The output is the input word delayed by one register, with three qualifiers. The valid flag marks the rectangle. A first-pixel marker flags the first word of each active line. A first-line marker flags the first word of the whole rectangle.

Top module: `win_crop`

## Requirements
- R1: While rst_ni is low, valid_o, first_pix_o, first_line_o and data_o are all 0.
- R2: The cycle in which lsync_i rises is column 0, and each later cycle adds one to the column. A word is horizontally active when h_start_i <= column <= h_start_i + h_len_i.
- R3: An active line lasts exactly h_len_i + 1 consecutive cycles when the line is long enough, and a programmed length of 0 gives a single cycle.
- R4: A rising edge of fsync_i sets the line index to 0. Each later rising edge of lsync_i adds one. A line sync that rises in the same cycle as the frame sync does not add one.
- R5: A word is vertically active when v_start_i <= line index <= v_start_i + v_len_i, so v_len_i + 1 lines are active.
- R6: The four window inputs are captured when fsync_i rises and apply from that cycle onward. Changes made at any other time have no effect until the next frame sync rise.
- R7: A window that reaches past the end of a line or frame is cut off by the next line sync or frame sync, and no other output reacts.
- R8: first_pix_o pulses for one cycle, together with valid_o, on the first active word of each active line.
- R9: first_line_o pulses only on the first active word of the first active line of a frame.
- R10: data_o equals data_i from one cycle earlier, unconditionally. All flags are aligned to that same delayed word.
- R11: The column and line counters saturate. After reset, no word is active until a line sync and a frame sync have both risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, active high |
| lsync_i | input | 1 | Line sync, active high |
| data_i | input | DATA_W | Input bus word |
| h_start_i | input | CFG_W | First active column, in cycles after the line sync |
| h_len_i | input | CFG_W | Active cycles per line, minus one |
| v_start_i | input | CFG_W | First active line after the frame sync |
| v_len_i | input | CFG_W | Active lines, minus one |
| data_o | output | DATA_W | Delayed data word |
| valid_o | output | 1 | Word lies inside the window |
| first_pix_o | output | 1 | First active word of a line |
| first_line_o | output | 1 | First active word of the frame |

## Verification
The assertions assume that fsync_i rises only in a cycle where lsync_i also rises. A frame sync in mid-line would swap the window and reset the line index partway through a run, and that would break the contiguous-run and marker properties. The bench builds every frame as a series of lines, each opening with a two-cycle line sync, and raises the frame sync only together with the first line sync of a frame. Line lengths, frame heights, windows and mid-frame setting changes are drawn at random within that shape.

// File: rtl/win_crop_pkg.sv
package win_crop_pkg;
  parameter int unsigned CFG_W = 15;

  typedef struct packed {
    logic [CFG_W-1:0] h_start;
    logic [CFG_W-1:0] h_len;
    logic [CFG_W-1:0] v_start;
    logic [CFG_W-1:0] v_len;
  } win_cfg_t;
endpackage

// File: rtl/win_edge.sv
module win_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/win_shadow.sv
module win_shadow
  import win_crop_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  win_cfg_t cfg_i,
  output win_cfg_t cfg_o
);
  win_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  // new settings apply already in the capture cycle
  assign cfg_o = load_i ? cfg_i : cfg_q;
endmodule

// File: rtl/win_axis.sv
module win_axis #(
  parameter int unsigned CFG_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CFG_W-1:0] start_i,
  input  logic [CFG_W-1:0] len_i,
  output logic             in_o,
  output logic             at_first_o
);
  localparam int unsigned CW = CFG_W + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] cnt_q, cnt_d, first_pos, last_pos;

  // one spare bit: last_pos never reaches SAT, so a saturated count is inactive
  always_comb begin
    if (clr_i)                       cnt_d = '0;
    else if (inc_i && cnt_q != SAT)  cnt_d = cnt_q + 1'b1;
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= SAT;
    else         cnt_q <= cnt_d;
  end

  assign first_pos  = {1'b0, start_i};
  assign last_pos   = first_pos + {1'b0, len_i};
  assign in_o       = (cnt_d >= first_pos) && (cnt_d <= last_pos);
  assign at_first_o = (cnt_d == first_pos);
endmodule

// File: rtl/win_crop.sv
module win_crop
  import win_crop_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              lsync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CFG_W-1:0]  h_start_i,
  input  logic [CFG_W-1:0]  h_len_i,
  input  logic [CFG_W-1:0]  v_start_i,
  input  logic [CFG_W-1:0]  v_len_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              first_pix_o,
  output logic              first_line_o
);
  logic     fs_rise, ls_rise;
  win_cfg_t cfg_in, cfg_eff;
  logic     h_in, h_first, v_in, v_first;
  logic     act, fp, fl;

  win_edge i_fs_edge (.clk_i, .rst_ni, .sig_i(fsync_i), .rise_o(fs_rise));
  win_edge i_ls_edge (.clk_i, .rst_ni, .sig_i(lsync_i), .rise_o(ls_rise));

  assign cfg_in = '{h_start: h_start_i, h_len: h_len_i,
                    v_start: v_start_i, v_len: v_len_i};

  win_shadow i_shadow (
    .clk_i, .rst_ni, .load_i(fs_rise), .cfg_i(cfg_in), .cfg_o(cfg_eff)
  );

  win_axis #(.CFG_W(CFG_W)) i_h_axis (
    .clk_i, .rst_ni,
    .clr_i(ls_rise), .inc_i(1'b1),
    .start_i(cfg_eff.h_start), .len_i(cfg_eff.h_len),
    .in_o(h_in), .at_first_o(h_first)
  );

  // frame clear wins over a coincident line increment
  win_axis #(.CFG_W(CFG_W)) i_v_axis (
    .clk_i, .rst_ni,
    .clr_i(fs_rise), .inc_i(ls_rise),
    .start_i(cfg_eff.v_start), .len_i(cfg_eff.v_len),
    .in_o(v_in), .at_first_o(v_first)
  );

  assign act = h_in & v_in;
  assign fp  = act & h_first;
  assign fl  = fp & v_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o       <= '0;
      valid_o      <= 1'b0;
      first_pix_o  <= 1'b0;
      first_line_o <= 1'b0;
    end else begin
      data_o       <= data_i;
      valid_o      <= act;
      first_pix_o  <= fp;
      first_line_o <= fl;
    end
  end
endmodule

// File: rtl/win_crop_chk.sv
module win_crop_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lsync_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              first_pix_o,
  input logic              first_line_o
);
  logic past_ok, ls_prev, seen_ls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      ls_prev <= 1'b0;
      seen_ls <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      ls_prev <= lsync_i;
      if (lsync_i && !ls_prev) seen_ls <= 1'b1;
    end
  end

  AST_PIX_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_pix_o |-> valid_o); // R8

  AST_RUN_OPENS_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> first_pix_o); // R8

  AST_LINE_HAS_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_line_o |-> first_pix_o); // R9

  AST_RUN_CONTIGUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !first_pix_o) |-> $past(valid_o)); // R3

  AST_DATA_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> data_o == $past(data_i)); // R10

  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_ls |-> !valid_o); // R11
endmodule

bind win_crop win_crop_chk #(.DATA_W(DATA_W)) i_win_crop_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lsync_i(lsync_i), .data_i(data_i),
  .data_o(data_o), .valid_o(valid_o), .first_pix_o(first_pix_o),
  .first_line_o(first_line_o)
);

// File: tb/test_win_crop.sv
module test_win_crop;
  localparam int DW = 12;
  localparam int CW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, ls = 1'b0;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] hs = '0, hl = '0, vs = '0, vl = '0;
  logic [DW-1:0] dout;
  logic vld, fpx, fln;

  always #10 clk = ~clk;

  win_crop #(.DATA_W(DW)) i_win_crop (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fs), .lsync_i(ls), .data_i(din),
    .h_start_i(hs), .h_len_i(hl), .v_start_i(vs), .v_len_i(vl),
    .data_o(dout), .valid_o(vld), .first_pix_o(fpx), .first_line_o(fln)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  string tag = "R2";

  // reference state
  logic [15:0] m_h, m_l;
  logic m_fsp, m_lsp;
  logic [CW-1:0] s_hs, s_hl, s_vs, s_vl;
  logic e_v, e_fp, e_fl, have_exp;
  logic [DW-1:0] e_d;

  function automatic logic hit(logic [15:0] p, logic [CW-1:0] st, logic [CW-1:0] ln);
    logic [15:0] a = {1'b0, st};
    logic [15:0] b = a + {1'b0, ln};
    return (p >= a) && (p <= b);
  endfunction

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", req, nm, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_h = '1; m_l = '1; m_fsp = 0; m_lsp = 0;
    s_hs = '0; s_hl = '0; s_vs = '0; s_vl = '0;
    have_exp = 0;
  endtask

  task automatic model_step();
    logic fr, lr, hi, vi;
    fr = fs & ~m_fsp;
    lr = ls & ~m_lsp;
    if (fr) begin s_hs = hs; s_hl = hl; s_vs = vs; s_vl = vl; end
    m_h = lr ? 16'd0 : (m_h != 16'hFFFF ? m_h + 16'd1 : m_h);
    if (fr) m_l = 16'd0;
    else if (lr && m_l != 16'hFFFF) m_l = m_l + 16'd1;
    hi = hit(m_h, s_hs, s_hl);
    vi = hit(m_l, s_vs, s_vl);
    e_v  = hi & vi;
    e_fp = e_v & (m_h == {1'b0, s_hs});
    e_fl = e_fp & (m_l == {1'b0, s_vs});
    e_d  = din;
    m_fsp = fs; m_lsp = ls;
    have_exp = 1;
  endtask

  task automatic cycle(logic f, logic l);
    @(negedge clk);
    cyc++;
    if (have_exp) begin
      chk(tag, "valid", {31'd0, vld}, {31'd0, e_v});
      chk("R8", "first_pix", {31'd0, fpx}, {31'd0, e_fp});
      chk("R9", "first_line", {31'd0, fln}, {31'd0, e_fl});
      chk("R10", "data", {20'd0, dout}, {20'd0, e_d});
    end
    fs = f; ls = l;
    din = DW'($urandom);
    model_step();
  endtask

  task automatic set_cfg(int a, int b, int c, int d);
    hs = CW'(a); hl = CW'(b); vs = CW'(c); vl = CW'(d);
  endtask

  // mid: line index at which the inputs are scrambled (R6); -1 for none
  task automatic frame(int nlines, int llen, int mid);
    for (int ln = 0; ln < nlines; ln++) begin
      if (ln == mid) set_cfg($urandom_range(0, 9), $urandom_range(0, 9),
                             $urandom_range(0, 4), $urandom_range(0, 4));
      for (int c = 0; c < llen; c++)
        cycle(ln == 0 && c < 3, c < 2);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "valid_rst", {31'd0, vld}, 32'd0);
    chk("R1", "first_pix_rst", {31'd0, fpx}, 32'd0);
    chk("R1", "first_line_rst", {31'd0, fln}, 32'd0);
    chk("R1", "data_rst", {20'd0, dout}, 32'd0);
    rst_n = 1'b1;

    // R11: zero window, no syncs yet, nothing may be active
    tag = "R11";
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
    // line syncs without frame sync still keep the line count saturated
    for (int i = 0; i < 12; i++) cycle(1'b0, i < 2);

    tag = "R2";  set_cfg(3, 5, 1, 2);   frame(6, 20, -1);
    tag = "R3";  set_cfg(0, 0, 0, 0);   frame(4, 16, -1);
    tag = "R5";  set_cfg(4, 3, 2, 0);   frame(5, 18, -1);
    tag = "R7";  set_cfg(14, 30, 3, 9); frame(6, 18, -1);
    tag = "R7";  set_cfg(2, 3, 30, 3);  frame(4, 12, -1);
    tag = "R6";  set_cfg(5, 4, 1, 2);   frame(6, 20, 2);
    tag = "R4";  set_cfg(1, 2, 0, 1);   frame(3, 14, -1);

    tag = "R6";
    for (int k = 0; k < 8; k++) begin
      set_cfg($urandom_range(0, 20), $urandom_range(0, 20),
              $urandom_range(0, 6), $urandom_range(0, 6));
      frame($urandom_range(4, 10), $urandom_range(8, 40),
            ($urandom_range(0, 1) != 0) ? 1 : -1);
    end
    tag = "R2";
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule